// File: doc/BRIEF.md
# Reversible Branch Condition-Code Unit

This unit holds the condition code that conditional branches consult. The code is four bits wide, and each bit is the ready answer for one kind of branch: bit 3 for "positive and non-zero", bit 2 for "non-zero", bit 1 for "negative" and bit 0 for "no overflow". A bit of 1 means that branch is taken. The ALU reports how each result classifies (zero, negative, overflow, or positive when none of them is set), and the unit turns that report into the matching code.

A reverse command rewrites the code so that the next branch answers the opposite question. In that state the four bits mean, from bit 3 to bit 0, "negative or zero", "zero", "positive or zero" and "overflow". The rewrite is not a plain complement. A separate flag records that the code is reversed. While the flag is set, ALU updates are dropped. Any branch query made in the reversed state returns the code to its normal form on the following edge.

A one-entry holding register keeps a copy of the code and the flag. The copy is written by an explicit save or on task entry, and read back by an explicit restore or on task exit.

Top module: `cc_branch_unit`

## Requirements
- R1: After reset the code is 4'b0001 (the zero-result code), the reversed flag is 0, and the holding register contains the same pair.
- R2: An ALU update in the normal state loads 4'b0000 if res_ovf is set. Otherwise it loads 4'b0001 if res_zero is set, else 4'b0111 if res_neg is set, else 4'b1101 (positive). Overflow has priority over zero, and zero over negative.
- R3: br_taken is br_valid AND the code bit picked by br_type, in the same cycle. Type 0 selects bit 3 (positive non-zero), type 1 bit 2 (non-zero), type 2 bit 1 (negative) and type 3 bit 0 (no overflow).
- R4: A reverse command in the normal state sets the flag and maps the code as follows: 0001 to 1110, 1101 to 0010, 0111 to 1000, 0000 to 0001.
- R5: A reverse command while the flag is already set has no effect.
- R6: While the flag is set, ALU updates leave the code and the flag unchanged.
- R7: A branch query while the flag is set maps the code back (1110 to 0001, 0010 to 1101, 1000 to 0111, 0001 to 0000) and clears the flag. A query in the normal state changes nothing.
- R8: save_cmd copies the code and the flag, as they stood before the edge, into the holding register. restore_cmd loads both back.
- R9: task_enter acts exactly as a save, and task_exit exactly as a restore.
- R10: When commands coincide, restore takes priority over branch normalisation, which takes priority over reverse, which takes priority over an ALU update. A save always captures the state from before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_valid | input | 1 | ALU result classification is valid this cycle |
| res_zero | input | 1 | Result is zero |
| res_neg | input | 1 | Result is negative |
| res_ovf | input | 1 | Result overflowed |
| rev_cmd | input | 1 | Reverse the sense of the next branch |
| br_valid | input | 1 | Conditional branch query this cycle |
| br_type | input | 2 | Branch kind selecting a code bit |
| save_cmd | input | 1 | Copy code and flag to the holding register |
| restore_cmd | input | 1 | Load code and flag from the holding register |
| task_enter | input | 1 | Task entry, automatic save |
| task_exit | input | 1 | Task exit, automatic restore |
| br_taken | output | 1 | Branch answer for the current query |
| cc_code | output | 4 | Current condition code |
| cc_reversed | output | 1 | Reversed flag |

## Verification
The assertions assume that every command input is 0 or 1 after reset, and that br_type holds a known value whenever br_valid is high. They do not assume that commands arrive one at a time, because the priority rule covers every overlap. The stimulus drives all inputs to defined levels on the falling edge. It deliberately combines queries, reverses, saves and updates in the same cycle so that the priority order is exercised while those assumptions still hold.

// File: rtl/cc_pkg.sv
package cc_pkg;
    localparam int CC_W = 4;
    localparam int BT_W = 2;

    typedef logic [CC_W-1:0] cc_code_t;
    typedef logic [BT_W-1:0] br_type_t;

    // normal-state codes
    localparam cc_code_t CC_ZERO = 4'b0001;
    localparam cc_code_t CC_POS  = 4'b1101;
    localparam cc_code_t CC_NEG  = 4'b0111;
    localparam cc_code_t CC_OVF  = 4'b0000;
    // reversed-state codes
    localparam cc_code_t CC_RZERO = 4'b1110;
    localparam cc_code_t CC_RPOS  = 4'b0010;
    localparam cc_code_t CC_RNEG  = 4'b1000;
    localparam cc_code_t CC_ROVF  = 4'b0001;

    typedef struct packed {
        cc_code_t code;
        logic     rev;
    } cc_state_t;

    localparam cc_state_t CC_RESET = '{code: CC_ZERO, rev: 1'b0};
endpackage

// File: rtl/cc_classify.sv
module cc_classify
    import cc_pkg::*;
(
    input  logic     res_zero,
    input  logic     res_neg,
    input  logic     res_ovf,
    output cc_code_t code
);
    always_comb begin
        if (res_ovf)       code = CC_OVF;
        else if (res_zero) code = CC_ZERO;
        else if (res_neg)  code = CC_NEG;
        else               code = CC_POS;
    end
endmodule

// File: rtl/cc_sense_map.sv
module cc_sense_map
    import cc_pkg::*;
(
    input  cc_code_t code_in,
    output cc_code_t rev_code,
    output cc_code_t norm_code
);
    // normal -> reversed
    always_comb begin
        unique case (code_in)
            CC_ZERO: rev_code = CC_RZERO;
            CC_POS:  rev_code = CC_RPOS;
            CC_NEG:  rev_code = CC_RNEG;
            CC_OVF:  rev_code = CC_ROVF;
            default: rev_code = code_in;
        endcase
    end

    // reversed -> normal
    always_comb begin
        unique case (code_in)
            CC_RZERO: norm_code = CC_ZERO;
            CC_RPOS:  norm_code = CC_POS;
            CC_RNEG:  norm_code = CC_NEG;
            CC_ROVF:  norm_code = CC_OVF;
            default:  norm_code = code_in;
        endcase
    end
endmodule

// File: rtl/cc_hold_reg.sv
module cc_hold_reg
    import cc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      capture,
    input  cc_state_t cur,
    output cc_state_t held
);
    cc_state_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (capture) hold_d = cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= CC_RESET;
        else        hold_q <= hold_d;
    end

    assign held = hold_q;

    // R8 / R9: a capture lands one edge later
    p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (hold_q == $past(cur)));
    p_hold_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(hold_q));
endmodule

// File: rtl/cc_branch_unit.sv
module cc_branch_unit
    import cc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd_valid,
    input  logic            res_zero,
    input  logic            res_neg,
    input  logic            res_ovf,
    input  logic            rev_cmd,
    input  logic            br_valid,
    input  logic [BT_W-1:0] br_type,
    input  logic            save_cmd,
    input  logic            restore_cmd,
    input  logic            task_enter,
    input  logic            task_exit,
    output logic            br_taken,
    output logic [CC_W-1:0] cc_code,
    output logic            cc_reversed
);
    cc_state_t state_d, state_q;
    cc_state_t held;
    cc_code_t  upd_code, rev_code, norm_code;
    br_type_t  bit_sel;
    logic      do_save, do_restore;

    cc_classify u_classify (
        .res_zero (res_zero),
        .res_neg  (res_neg),
        .res_ovf  (res_ovf),
        .code     (upd_code)
    );

    cc_sense_map u_map (
        .code_in   (state_q.code),
        .rev_code  (rev_code),
        .norm_code (norm_code)
    );

    assign do_save    = save_cmd | task_enter;
    assign do_restore = restore_cmd | task_exit;

    cc_hold_reg u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (do_save),
        .cur     (state_q),
        .held    (held)
    );

    // branch kind 0 reads the top bit, kind 3 the bottom bit
    assign bit_sel  = br_type_t'(CC_W - 1) - br_type;
    assign br_taken = br_valid & state_q.code[bit_sel];

    always_comb begin
        state_d = state_q;
        if (do_restore) begin
            state_d = held;
        end else if (br_valid && state_q.rev) begin
            state_d.code = norm_code;
            state_d.rev  = 1'b0;
        end else if (rev_cmd && !state_q.rev) begin
            state_d.code = rev_code;
            state_d.rev  = 1'b1;
        end else if (upd_valid && !state_q.rev) begin
            state_d.code = upd_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CC_RESET;
        else        state_q <= state_d;
    end

    assign cc_code     = state_q.code;
    assign cc_reversed = state_q.rev;

    // R4 / R7: code always matches the flag's legal set
    p_legal_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.rev ? (state_q.code == CC_RZERO || state_q.code == CC_RPOS ||
                       state_q.code == CC_RNEG  || state_q.code == CC_ROVF)
                    : (state_q.code == CC_ZERO  || state_q.code == CC_POS  ||
                       state_q.code == CC_NEG   || state_q.code == CC_OVF));
    p_no_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.rev && !br_valid && !do_restore) |=> ($stable(state_q)));
    p_reverse_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_cmd && !state_q.rev && !do_restore) |=> state_q.rev);
    p_branch_norm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && state_q.rev && !do_restore) |=> !state_q.rev);
    p_ovf_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && res_ovf && !state_q.rev && !rev_cmd && !do_restore)
        |=> (state_q.code == CC_OVF));
    p_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        do_restore |=> (state_q == $past(held)));
endmodule

// File: tb/cc_branch_unit_tb.sv
module cc_branch_unit_tb_top;
    import cc_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic upd_valid = 0, res_zero = 0, res_neg = 0, res_ovf = 0;
    logic rev_cmd = 0, br_valid = 0, save_cmd = 0, restore_cmd = 0;
    logic task_enter = 0, task_exit = 0;
    logic [1:0] br_type = 2'd0;
    logic br_taken, cc_reversed;
    logic [3:0] cc_code;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cc_branch_unit dut_i (
        .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .res_zero(res_zero),
        .res_neg(res_neg), .res_ovf(res_ovf), .rev_cmd(rev_cmd),
        .br_valid(br_valid), .br_type(br_type), .save_cmd(save_cmd),
        .restore_cmd(restore_cmd), .task_enter(task_enter),
        .task_exit(task_exit), .br_taken(br_taken), .cc_code(cc_code),
        .cc_reversed(cc_reversed)
    );

    typedef struct packed {
        logic       upd, z, n, o, rv, qv;
        logic [1:0] qt;
        logic       sv, rs, et;
        logic [3:0] ec;
        logic       er;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{1,0,0,0, 0,1,2'd0, 0,0, 0, 4'b1101, 0},  // R2 positive, R3 query normal
        '{0,0,0,0, 0,1,2'd0, 0,0, 1, 4'b1101, 0},  // R3 type0
        '{0,0,0,0, 1,0,2'd0, 0,0, 0, 4'b0010, 1},  // R4 positive reversed
        '{1,0,1,0, 0,0,2'd0, 0,0, 0, 4'b0010, 1},  // R6 update ignored
        '{0,0,0,0, 1,0,2'd0, 0,0, 0, 4'b0010, 1},  // R5 second reverse ignored
        '{0,0,0,0, 0,1,2'd2, 0,0, 1, 4'b1101, 0},  // R7 back to normal
        '{1,0,1,0, 0,0,2'd0, 0,0, 0, 4'b0111, 0},  // R2 negative
        '{0,0,0,0, 0,0,2'd0, 1,0, 0, 4'b0111, 0},  // R8 save
        '{0,0,0,0, 0,1,2'd1, 0,0, 1, 4'b0111, 0},  // R3 type1
        '{0,0,0,0, 1,0,2'd0, 0,0, 0, 4'b1000, 1},  // R4 negative reversed
        '{1,0,0,1, 0,0,2'd0, 0,0, 0, 4'b1000, 1},  // R6 overflow update ignored
        '{0,0,0,0, 0,0,2'd0, 0,1, 0, 4'b0111, 0},  // R8 restore
        '{1,1,0,0, 0,1,2'd3, 0,0, 1, 4'b0001, 0},  // R2 zero, R3 type3
        '{0,0,0,0, 1,0,2'd0, 0,0, 0, 4'b1110, 1},  // R4 zero reversed
        '{0,0,0,0, 0,1,2'd3, 0,0, 0, 4'b0001, 0},  // R7 zero back
        '{1,1,1,1, 0,0,2'd0, 0,0, 0, 4'b0000, 0},  // R2 overflow priority
        '{0,0,0,0, 1,1,2'd3, 0,0, 0, 4'b0001, 1},  // R4 overflow reversed, R10
        '{0,0,0,0, 0,1,2'd3, 0,0, 1, 4'b0000, 0},  // R7 overflow back
        '{0,0,0,0, 1,1,2'd1, 0,0, 0, 4'b0001, 1},  // R10 normal query + reverse
        '{0,0,0,0, 1,1,2'd0, 0,0, 0, 4'b0000, 0}   // R10 branch beats reverse
    };
    localparam string TAGS [NV] = '{
        "R2", "R3", "R4", "R6", "R5", "R7", "R2", "R8", "R3", "R4",
        "R6", "R8", "R2", "R4", "R7", "R2", "R4", "R7", "R10", "R10"
    };

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic idle();
        upd_valid = 0; res_zero = 0; res_neg = 0; res_ovf = 0; rev_cmd = 0;
        br_valid = 0; br_type = 0; save_cmd = 0; restore_cmd = 0;
        task_enter = 0; task_exit = 0;
    endtask

    task automatic step_check(input string tag, input logic [3:0] ec, input logic er);
        @(negedge clk);
        check(tag, {cc_code, cc_reversed}, {ec, er});
    endtask

    initial begin
        idle();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", {cc_code, cc_reversed}, {4'b0001, 1'b0});
        restore_cmd = 1;
        step_check("R1", 4'b0001, 1'b0);  // R1 holding register reset value
        idle();

        for (int i = 0; i < NV; i++) begin
            upd_valid = TBL[i].upd; res_zero = TBL[i].z; res_neg = TBL[i].n;
            res_ovf = TBL[i].o; rev_cmd = TBL[i].rv; br_valid = TBL[i].qv;
            br_type = TBL[i].qt; save_cmd = TBL[i].sv; restore_cmd = TBL[i].rs;
            #2;
            check(TAGS[i], {4'b0, br_taken}, {4'b0, TBL[i].et});
            step_check(TAGS[i], TBL[i].ec, TBL[i].er);
            idle();
        end

        // R9 task entry/exit, R10 save sees pre-edge state
        upd_valid = 1;
        step_check("R2", 4'b1101, 1'b0);
        idle(); task_enter = 1; upd_valid = 1; res_neg = 1;
        step_check("R10", 4'b0111, 1'b0);
        idle(); rev_cmd = 1;
        step_check("R4", 4'b1000, 1'b1);
        idle(); task_exit = 1;
        step_check("R9", 4'b1101, 1'b0);
        // R10 restore beats update and reverse
        idle(); task_exit = 1; upd_valid = 1; res_ovf = 1; rev_cmd = 1;
        step_check("R10", 4'b1101, 1'b0);
        idle();
        br_valid = 1; br_type = 2'd2;
        #2 check("R3", {4'b0, br_taken}, 5'b0);
        idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule